// File: doc/BRIEF.md
# Weighted-SAD Inter Mode Preselector

This block sits in front of a rate-distortion mode-decision pipeline. It scores each inter-prediction candidate of one macroblock with a cheap cost of its own, and it hands on only a short list of candidates for the expensive evaluation. The list holds the three cheapest inter candidates, plus the skip/direct candidate and the one intra candidate that was already chosen. Those last two are added every time.

Rows of pixels arrive one per cycle. Each row holds eight original pixels and the eight predicted pixels for the same positions, tagged with the inter mode they belong to. All 48 rows of one mode are sent back to back: six 8x8 blocks (four luma, U, V) of eight rows each. The block sums the absolute differences of a row, then sums rows into a block total, then block totals into a macroblock total.

On the 48th row it forms the mode's cost: the macroblock SAD, plus a lambda-weighted header-bit estimate supplied with that row, plus a programmable per-mode offset. It then inserts the mode into a running, sorted top-three list. When all five inter modes have been scored, a one-cycle `done` pulse marks the final list. A `start` pulse clears everything for the next macroblock.

Top module: `wsad_presel`

## Requirements
- R1: The SAD of a row is the sum of the eight lane absolute differences. Lane l of `orig_row` and `pred_row` is bits [8l+7:8l], an unsigned pixel.
- R2: A mode's cost is the SAD summed over its 48 accepted rows, plus `lambda` times `hdr_bits`, plus the offset table entry of that mode. The 48 rows are six blocks of eight rows. `hdr_bits` and `row_mode` are taken from the 48th row. The cost saturates at 2^20-1.
- R3: Mode codes are 0=16x16, 1=16x8, 2=8x16, 3=8x8 with preselected direction, and 4=8x8 direct. At `done`, slots 0..2 of `cand_list` (bits [2:0], [5:3], [8:6]) hold the three cheapest inter modes in ascending cost order. Slot k of `cand_cost` (bits [20k+19:20k]) holds the cost of slot k.
- R4: When two costs are equal, the lower mode code is ranked first.
- R5: Slot 3 of `cand_list` (bits [11:9]) always carries code 5 (skip/direct). Slot 4 (bits [14:12]) always carries code 6 (intra).
- R6: A cycle with `ofs_wr` high and `ofs_addr` below 5 writes `ofs_wdata` into that mode's offset. Addresses 5 to 7 change nothing. All offsets reset to zero. A write in the same cycle as a mode's 48th row does not affect that row's cost; the old value is used.
- R7: `done` is high for exactly one cycle. That cycle follows the clock edge that accepts the 48th row of the fifth distinct inter mode since `start`.
- R8: `start` clears the row/block/macroblock sums, the ranking (slot costs read zero) and the record of scored modes. A row presented in the same cycle as `start` is dropped.
- R9: A row whose `row_mode` is 5, 6 or 7 is not accepted. It does not advance the row count or change any sum.
- R10: After reset, `done` is low, slots 0..2 of `cand_list` are 0, and `cand_cost` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new macroblock; clears all state |
| row_vld | input | 1 | A pixel row is presented |
| row_mode | input | 3 | Inter mode code of the row |
| orig_row | input | 64 | Eight original pixels, lane l at [8l+7:8l] |
| pred_row | input | 64 | Eight predicted pixels, same lane layout |
| hdr_bits | input | 8 | Header-bit estimate, taken on a mode's 48th row |
| lambda | input | 8 | Lagrange weight |
| ofs_wr | input | 1 | Offset table write strobe |
| ofs_addr | input | 3 | Offset table entry (mode code) |
| ofs_wdata | input | 12 | Offset value |
| done | output | 1 | Final candidate list is valid (one-cycle pulse) |
| cand_list | output | 15 | Five 3-bit candidate codes, slot 0 in the low bits |
| cand_cost | output | 60 | Costs of slots 0..2, 20 bits each |

## Verification
Two events can share a cycle here, and the bench provokes each one directly.

The first is a `start` presented together with a valid row. The bench applies both in one cycle, then checks that the slot costs read zero. It then scores a full macroblock whose costs would come out wrong if that row had been counted.

The second is an offset write landing on the 48th row of the same mode. The bench writes a new offset on that exact cycle and expects the old offset in that mode's cost. It expects the new value to appear only in the following macroblock.

The reference model rebuilds every cost and the tie-broken ranking from pixel values, and checks the `done` timing on every clock.

// File: rtl/wsad_pkg.sv
// Shared constants and mode codes for the weighted-SAD preselector.
// Assumes codes 0..NUM_INTER-1 are inter candidates; higher codes are
// reserved for the always-forwarded candidates and for "no mode".
package wsad_pkg;
    localparam int MODE_W    = 3;
    localparam int NUM_INTER = 5;
    localparam int KEEP      = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_16X16  = 3'd0,
        MD_16X8   = 3'd1,
        MD_8X16   = 3'd2,
        MD_8X8    = 3'd3,
        MD_8X8DIR = 3'd4,
        MD_SKIP   = 3'd5,
        MD_INTRA  = 3'd6,
        MD_NONE   = 3'd7
    } mode_e;
endpackage

// File: rtl/wsad_row_sad.sv
// Row SAD: sums the absolute differences of LANES pixel pairs in one cycle.
// Purely combinational; assumes unsigned pixels packed lane 0 lowest.
module wsad_row_sad #(
    parameter int PIX_W = 8,
    parameter int LANES = 8,
    parameter int ROW_W = PIX_W + $clog2(LANES)
) (
    input  logic [LANES*PIX_W-1:0] orig,
    input  logic [LANES*PIX_W-1:0] pred,
    output logic [ROW_W-1:0]       row_sad
);
    logic [PIX_W-1:0] absd [LANES];

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [PIX_W-1:0] o_px, p_px;
            assign o_px = orig[l*PIX_W +: PIX_W];
            assign p_px = pred[l*PIX_W +: PIX_W];
            // absolute difference of one lane
            assign absd[l] = (o_px > p_px) ? (o_px - p_px) : (p_px - o_px);
        end
    endgenerate

    // adder tree collapsed into a loop: total of all lanes
    always_comb begin
        row_sad = '0;
        for (int i = 0; i < LANES; i++) begin
            row_sad = row_sad + ROW_W'(absd[i]);
        end
    end
endmodule

// File: rtl/wsad_accum.sv
// Block- and macroblock-level SAD adders with row/block counters.
// Assumes the rows of one mode arrive contiguously; mb_last and mb_sad
// are combinational and describe the row being accepted this cycle.
module wsad_accum #(
    parameter int ROW_W        = 11,
    parameter int SAD_W        = 17,
    parameter int ROWS_PER_BLK = 8,
    parameter int BLKS         = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acc_en,
    input  logic [ROW_W-1:0] row_sad,
    output logic             mb_last,
    output logic [SAD_W-1:0] mb_sad
);
    localparam int RC_W = $clog2(ROWS_PER_BLK + 1);
    localparam int BC_W = $clog2(BLKS + 1);

    logic [RC_W-1:0]  row_cnt;
    logic [BC_W-1:0]  blk_cnt;
    logic [SAD_W-1:0] blk_acc, mb_acc, blk_sum;
    logic             blk_end, blk_final;

    // running sums including the current row
    always_comb begin
        blk_sum   = blk_acc + SAD_W'(row_sad);
        mb_sad    = mb_acc + blk_sum;
        blk_end   = (row_cnt == RC_W'(ROWS_PER_BLK - 1));
        blk_final = (blk_cnt == BC_W'(BLKS - 1));
        mb_last   = acc_en && blk_end && blk_final;
    end

    // advance counters and fold block totals into the macroblock total
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row_cnt <= '0;
            blk_cnt <= '0;
            blk_acc <= '0;
            mb_acc  <= '0;
        end else if (acc_en) begin
            if (blk_end) begin
                row_cnt <= '0;
                blk_acc <= '0;
                if (blk_final) begin
                    blk_cnt <= '0;
                    mb_acc  <= '0;
                end else begin
                    blk_cnt <= blk_cnt + 1'b1;
                    mb_acc  <= mb_sad;
                end
            end else begin
                row_cnt <= row_cnt + 1'b1;
                blk_acc <= blk_sum;
            end
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_cnt < RC_W'(ROWS_PER_BLK)) && (blk_cnt < BC_W'(BLKS)));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (row_cnt == '0 && blk_cnt == '0 && blk_acc == '0 && mb_acc == '0));
endmodule

// File: rtl/wsad_ofs_tbl.sv
// Per-mode additive offset table: one register per inter mode.
// Assumes writes to addresses at or above NUM are to be ignored; the read
// port is combinational, so a same-cycle write is seen only afterwards.
module wsad_ofs_tbl #(
    parameter int NUM   = 5,
    parameter int AW    = 3,
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    wr_addr,
    input  logic [OFS_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [OFS_W-1:0] rd_data
);
    logic [OFS_W-1:0] tbl [NUM];

    genvar e;
    generate
        for (e = 0; e < NUM; e++) begin : g_ent
            // load one entry on a matching write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl[e] <= '0;
                end else if (wr && wr_addr == AW'(e)) begin
                    tbl[e] <= wr_data;
                end
            end
        end
    endgenerate

    // read the entry of the requested mode, zero for reserved codes
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rd_addr == AW'(i)) rd_data = tbl[i];
        end
    end

    // R6
    ofs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_addr < AW'(NUM)) |=> (tbl[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/wsad_rank.sv
// Running sorted top-K list of (cost, mode) entries.
// An entry ranks ahead on lower cost, then on lower mode code. Assumes each
// mode is inserted at most once between clears.
module wsad_rank #(
    parameter int K      = 3,
    parameter int COST_W = 20,
    parameter int MODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                ins_vld,
    input  logic [MODE_W-1:0]   ins_mode,
    input  logic [COST_W-1:0]   ins_cost,
    output logic [K*MODE_W-1:0] slot_mode,
    output logic [K*COST_W-1:0] slot_cost
);
    logic [K-1:0]      vld_q;
    logic [K-1:0]      beats;
    logic [MODE_W-1:0] mode_q [K];
    logic [COST_W-1:0] cost_q [K];

    genvar i;
    generate
        for (i = 0; i < K; i++) begin : g_slot
            // does the new entry rank ahead of this slot
            assign beats[i] = !vld_q[i] || (ins_cost < cost_q[i]) ||
                              (ins_cost == cost_q[i] && ins_mode < mode_q[i]);
            assign slot_mode[i*MODE_W +: MODE_W] = mode_q[i];
            assign slot_cost[i*COST_W +: COST_W] = cost_q[i];

            if (i == 0) begin : g_head
                // head slot takes the new entry whenever it wins
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        vld_q[i] <= 1'b0; mode_q[i] <= '0; cost_q[i] <= '0;
                    end else if (ins_vld && beats[i]) begin
                        vld_q[i] <= 1'b1; mode_q[i] <= ins_mode; cost_q[i] <= ins_cost;
                    end
                end
            end else begin : g_tail
                // later slots either shift down or take the new entry
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        vld_q[i] <= 1'b0; mode_q[i] <= '0; cost_q[i] <= '0;
                    end else if (ins_vld && beats[i]) begin
                        if (beats[i-1]) begin
                            vld_q[i]  <= vld_q[i-1];
                            mode_q[i] <= mode_q[i-1];
                            cost_q[i] <= cost_q[i-1];
                        end else begin
                            vld_q[i]  <= 1'b1;
                            mode_q[i] <= ins_mode;
                            cost_q[i] <= ins_cost;
                        end
                    end
                end

                // R3
                slot_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    vld_q[i] |-> vld_q[i-1]);

                // R4
                slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    vld_q[i] |-> ((cost_q[i-1] < cost_q[i]) ||
                                  (cost_q[i-1] == cost_q[i] && mode_q[i-1] < mode_q[i])));
            end
        end
    endgenerate
endmodule

// File: rtl/wsad_presel.sv
// Weighted-SAD inter mode preselector (top).
// Scores each inter mode as SAD + lambda*header bits + offset, keeps the
// KEEP cheapest, and always appends the skip/direct and intra codes.
// Assumes the 48 rows of a mode arrive contiguously, each mode once per start.
module wsad_presel
    import wsad_pkg::*;
#(
    parameter int PIX_W        = 8,
    parameter int LANES        = 8,
    parameter int ROWS_PER_BLK = 8,
    parameter int BLKS         = 6,
    parameter int LAM_W        = 8,
    parameter int HDR_W        = 8,
    parameter int OFS_W        = 12,
    parameter int COST_W       = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       row_vld,
    input  logic [MODE_W-1:0]          row_mode,
    input  logic [LANES*PIX_W-1:0]     orig_row,
    input  logic [LANES*PIX_W-1:0]     pred_row,
    input  logic [HDR_W-1:0]           hdr_bits,
    input  logic [LAM_W-1:0]           lambda,
    input  logic                       ofs_wr,
    input  logic [MODE_W-1:0]          ofs_addr,
    input  logic [OFS_W-1:0]           ofs_wdata,
    output logic                       done,
    output logic [(KEEP+2)*MODE_W-1:0] cand_list,
    output logic [KEEP*COST_W-1:0]     cand_cost
);
    localparam int ROW_W  = PIX_W + $clog2(LANES);
    localparam int SAD_W  = $clog2(ROWS_PER_BLK * BLKS * LANES * ((1 << PIX_W) - 1) + 1);
    localparam int PROD_W = LAM_W + HDR_W;
    localparam int MX1    = (SAD_W > PROD_W) ? SAD_W : PROD_W;
    localparam int MX2    = (MX1 > OFS_W) ? MX1 : OFS_W;
    localparam int WIDE_W = (MX2 + 2 > COST_W + 1) ? MX2 + 2 : COST_W + 1;
    localparam logic [WIDE_W-1:0] COST_MAX = WIDE_W'((64'd1 << COST_W) - 1);
    localparam logic [NUM_INTER-1:0] ALL_MODES = '1;

    logic                 accept, mb_last;
    logic [ROW_W-1:0]     row_sad;
    logic [SAD_W-1:0]     mb_sad;
    logic [OFS_W-1:0]     ofs_rd;
    logic [PROD_W-1:0]    hdr_term;
    logic [WIDE_W-1:0]    cost_wide;
    logic [COST_W-1:0]    cost;
    logic [NUM_INTER-1:0] mask_q, mask_nxt;
    logic                 done_q;
    logic [KEEP*MODE_W-1:0] rank_modes;

    // a row counts only outside start and for an inter mode code
    assign accept = row_vld && !start && (row_mode < MODE_W'(NUM_INTER));

    wsad_row_sad #(.PIX_W(PIX_W), .LANES(LANES), .ROW_W(ROW_W)) u_row (
        .orig(orig_row), .pred(pred_row), .row_sad(row_sad));

    wsad_accum #(.ROW_W(ROW_W), .SAD_W(SAD_W), .ROWS_PER_BLK(ROWS_PER_BLK),
                 .BLKS(BLKS)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(start), .acc_en(accept),
        .row_sad(row_sad), .mb_last(mb_last), .mb_sad(mb_sad));

    wsad_ofs_tbl #(.NUM(NUM_INTER), .AW(MODE_W), .OFS_W(OFS_W)) u_ofs (
        .clk(clk), .rst_n(rst_n), .wr(ofs_wr), .wr_addr(ofs_addr),
        .wr_data(ofs_wdata), .rd_addr(row_mode), .rd_data(ofs_rd));

    // weighted cost of the mode whose last row is being accepted, saturated
    always_comb begin
        hdr_term  = PROD_W'(lambda) * PROD_W'(hdr_bits);
        cost_wide = WIDE_W'(mb_sad) + WIDE_W'(hdr_term) + WIDE_W'(ofs_rd);
        cost      = (cost_wide > COST_MAX) ? {COST_W{1'b1}} : cost_wide[COST_W-1:0];
        mask_nxt  = mask_q | (NUM_INTER'(1) << row_mode);
    end

    wsad_rank #(.K(KEEP), .COST_W(COST_W), .MODE_W(MODE_W)) u_rank (
        .clk(clk), .rst_n(rst_n), .clr(start), .ins_vld(mb_last),
        .ins_mode(row_mode), .ins_cost(cost),
        .slot_mode(rank_modes), .slot_cost(cand_cost));

    // record scored modes and raise done once the set becomes complete
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            mask_q <= '0;
            done_q <= 1'b0;
        end else if (mb_last) begin
            mask_q <= mask_nxt;
            done_q <= (mask_nxt == ALL_MODES) && (mask_q != ALL_MODES);
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done      = done_q;
    assign cand_list = {MD_INTRA, MD_SKIP, rank_modes};

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(row_vld && !start));

    // R8
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && cand_cost == '0));
endmodule

// File: tb/tb_wsad_presel.sv
module tb_wsad_presel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        row_vld = 1'b0;
    logic [2:0]  row_mode = '0;
    logic [63:0] orig_row = '0;
    logic [63:0] pred_row = '0;
    logic [7:0]  hdr_bits = '0;
    logic [7:0]  lambda = '0;
    logic        ofs_wr = 1'b0;
    logic [2:0]  ofs_addr = '0;
    logic [11:0] ofs_wdata = '0;
    logic        done;
    logic [14:0] cand_list;
    logic [59:0] cand_cost;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    int mcost [5];
    bit mmask [5];
    int mofs  [5];

    wsad_presel dut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_vld(row_vld),
        .row_mode(row_mode), .orig_row(orig_row), .pred_row(pred_row),
        .hdr_bits(hdr_bits), .lambda(lambda), .ofs_wr(ofs_wr),
        .ofs_addr(ofs_addr), .ofs_wdata(ofs_wdata), .done(done),
        .cand_list(cand_list), .cand_cost(cand_cost));

    always #10 clk = ~clk;

    function automatic int opix(int seed, int r, int l);
        return (seed * 37 + r * 11 + l * 53) % 256;
    endfunction

    function automatic int ppix(int seed, int r, int l);
        return (seed * 91 + r * 5 + l * 17 + 3) % 256;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock; sample done a quarter period after the edge (R7)
    task automatic tick(input bit exp_d);
        @(posedge clk);
        #5;
        check(done === exp_d, "R7 done", int'(done), int'(exp_d));
    endtask

    task automatic model_clear();
        for (int j = 0; j < 5; j++) begin mmask[j] = 0; mcost[j] = 0; end
    endtask

    // R3 R4 R5: expected ranking rebuilt by selection from model costs
    task automatic check_list();
        bit used [5];
        for (int j = 0; j < 5; j++) used[j] = 0;
        for (int k = 0; k < 3; k++) begin
            int bj = -1;
            for (int j = 0; j < 5; j++)
                if (!used[j] && (bj < 0 || mcost[j] < mcost[bj])) bj = j;
            used[bj] = 1;
            check(int'(cand_list[k*3 +: 3]) == bj, "R3/R4 slot mode",
                  int'(cand_list[k*3 +: 3]), bj);
            check(int'(cand_cost[k*20 +: 20]) == mcost[bj], "R2/R3 slot cost",
                  int'(cand_cost[k*20 +: 20]), mcost[bj]);
        end
        check(cand_list[11:9] == 3'd5, "R5 skip slot", int'(cand_list[11:9]), 5);
        check(cand_list[14:12] == 3'd6, "R5 intra slot", int'(cand_list[14:12]), 6);
    endtask

    task automatic do_start();
        start = 1'b1;
        tick(1'b0);
        start = 1'b0;
        model_clear();
    endtask

    task automatic write_ofs(input int a, input int v);
        ofs_wr = 1'b1; ofs_addr = 3'(a); ofs_wdata = 12'(v);
        tick(1'b0);
        ofs_wr = 1'b0;
        if (a < 5) mofs[a] = v;   // R6: addresses 5..7 ignored
    endtask

    task automatic load_row(input int m, input int seed, input int r);
        row_vld = 1'b1;
        row_mode = 3'(m);
        for (int l = 0; l < 8; l++) begin
            orig_row[l*8 +: 8] = 8'(opix(seed, r, l));
            pred_row[l*8 +: 8] = 8'(ppix(seed, r, l));
        end
    endtask

    // send the 48 rows of one mode; optional reserved-code row (R9) and
    // offset write on the final row (R6)
    task automatic send_mode(input int m, input int seed, input int hdr,
                             input bit inj, input bit wr_last, input int wr_val);
        int sad = 0;
        bit full_before, full_after, exp_d;
        for (int r = 0; r < 48; r++)
            for (int l = 0; l < 8; l++) begin
                int d = opix(seed, r, l) - ppix(seed, r, l);
                sad += (d < 0) ? -d : d;   // R1
            end
        for (int r = 0; r < 48; r++) begin
            if (inj && r == 20) begin
                load_row(7, seed + 50, r);   // R9: must be ignored
                tick(1'b0);
            end
            load_row(m, seed, r);
            hdr_bits = 8'(hdr);
            exp_d = 1'b0;
            if (r == 47) begin
                full_before = 1;
                for (int j = 0; j < 5; j++) full_before &= mmask[j];
                mcost[m] = sad + int'(lambda) * hdr + mofs[m];   // R2
                mmask[m] = 1;
                full_after = 1;
                for (int j = 0; j < 5; j++) full_after &= mmask[j];
                exp_d = full_after && !full_before;
                if (wr_last) begin
                    ofs_wr = 1'b1; ofs_addr = 3'(m); ofs_wdata = 12'(wr_val);
                end
            end
            tick(exp_d);
            if (exp_d) check_list();
        end
        row_vld = 1'b0;
        if (wr_last) begin
            ofs_wr = 1'b0;
            mofs[m] = wr_val;
        end
    endtask

    initial begin
        for (int j = 0; j < 5; j++) mofs[j] = 0;
        model_clear();
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        tick(1'b0);
        // R10 reset state
        check(cand_list[8:0] == 9'd0, "R10 reset modes", int'(cand_list[8:0]), 0);
        check(cand_cost == '0, "R10 reset costs", int'(cand_cost[19:0]), 0);
        check(cand_list[14:9] == {3'd6, 3'd5}, "R5 at reset", int'(cand_list[14:9]), 53);

        // A: distinct costs, modes in natural order, zero offsets
        lambda = 8'd4;
        do_start();
        send_mode(0, 1, 10, 0, 0, 0);
        send_mode(1, 2, 3, 0, 0, 0);
        send_mode(2, 3, 20, 0, 0, 0);
        send_mode(3, 4, 7, 0, 0, 0);
        send_mode(4, 5, 1, 0, 0, 0);
        tick(1'b0);   // R7: pulse lasts one cycle

        // B: offsets reorder, reverse order, reserved-code row, ignored address
        write_ofs(0, 1500);
        write_ofs(1, 900);
        write_ofs(3, 0);
        write_ofs(6, 4000);   // R6 ignored address
        lambda = 8'd2;
        do_start();
        send_mode(4, 7, 9, 0, 0, 0);
        send_mode(3, 8, 2, 0, 0, 0);
        send_mode(2, 9, 30, 1, 0, 0);
        send_mode(1, 10, 4, 0, 0, 0);
        send_mode(0, 11, 0, 0, 0, 0);

        // C: all costs equal (R4), offset write on final row of mode 0 (R6)
        write_ofs(0, 0);
        write_ofs(1, 0);
        lambda = 8'd3;
        do_start();
        send_mode(4, 3, 5, 0, 0, 0);
        send_mode(3, 3, 5, 0, 0, 0);
        send_mode(2, 3, 5, 0, 0, 0);
        send_mode(1, 3, 5, 0, 0, 0);
        send_mode(0, 3, 5, 0, 1, 2000);

        // D: start together with a row (R8), then a full macroblock using new offset
        load_row(0, 99, 0);
        start = 1'b1;
        tick(1'b0);
        start = 1'b0;
        row_vld = 1'b0;
        model_clear();
        check(cand_cost == '0, "R8 costs cleared", int'(cand_cost[19:0]), 0);
        lambda = 8'd1;
        send_mode(0, 20, 6, 0, 0, 0);
        send_mode(2, 21, 6, 0, 0, 0);
        send_mode(1, 22, 6, 0, 0, 0);
        send_mode(4, 23, 6, 0, 0, 0);
        send_mode(3, 24, 6, 0, 0, 0);
        tick(1'b0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule